// File: doc/BRIEF.md
# Dual-Clock FIFO with Conservative Status Flags

This block is a first-in first-out buffer that connects a producer and a consumer running on two unrelated clocks. Words are written on the write clock into a dual-port storage array and read back in the same order on the read clock. A read returns its word one read-clock cycle after it is accepted. Each side keeps its own binary position counter. The Gray-coded form of each counter passes into the other clock domain through a chain of flip-flop synchronizer stages.

The write side drives a registered full flag and a write-error flag. The read side drives a registered empty flag, an almost-empty flag and a read-error flag. The almost-empty flag has a threshold set by a parameter. Each flag is computed from the opposite side's position as last synchronized, which may be out of date. Because of this, full and empty may report "no room" or "nothing to read" a few cycles longer than the true state, but never the other way round. In the same way, the almost-empty flag may under-count the stored words but never over-counts them.

Each side has its own synchronous reset. After that reset is released, the side raises a busy output for a fixed number of its own clock cycles. While busy is high, the side keeps its counter at zero and refuses accesses. Any refused access (a write when full, a read when empty, or any access while busy) raises that side's error flag. The error flag stays high while the refused request is held and clears in the cycle after the enable drops or the blocking condition ends.

Top module: `dcf_fifo`

## Requirements
- R1: Words come out in the order they were written. The word for a read accepted at a read-clock edge is presented on `rd_data` at that same edge, so it can be sampled before the next edge.
- R2: With no reads in progress, `full` goes high at the same write-clock edge that accepts the DEPTH-th stored word (DEPTH = 2**ADDR_W, 16 by default). A write attempted while `full` is high is discarded and does not move the write position.
- R3: `wr_err` is registered on the write clock. It is 1 in the cycle after a write is attempted while `full` or `wr_busy` is high, and 0 in the cycle after `wr_en` is low or neither `full` nor `wr_busy` was high.
- R4: A read attempted while `empty` is high returns nothing and does not move the read position. `rd_err` is registered on the read clock and is 1 in the cycle after such a read. It is 0 in the cycle after `rd_en` is low.
- R5: A read attempted while `rd_busy` is high is refused and raises `rd_err` in the next read-clock cycle.
- R6: After its reset is released, each side holds its busy output high for exactly BUSY_CYC of its own clock cycles. Accesses during that window store nothing and return nothing.
- R7: After both sides have been idle for several cycles of each clock, `prog_empty` is 1 exactly when the stored word count is at or below AE_LEVEL (3 by default). At no time does it read 0 while the stored count is at or below AE_LEVEL.
- R8: While reset is held, the outputs are: `full`=0, `empty`=1, `prog_empty`=1, `wr_err`=0, `rd_err`=0, `wr_busy`=1 and `rd_busy`=1.
- R9: Flag release crosses the clock domains. `full` is still 1 right after the first read from a full FIFO and drops within 8 write-clock cycles. `empty` is still 1 right after the first write into an empty FIFO and drops within 8 read-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset of the write side |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Word to store |
| full | output | 1 | No room for another word (registered) |
| wr_err | output | 1 | Previous write was refused |
| wr_busy | output | 1 | Write side still coming out of reset |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset of the read side |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Word returned by the last accepted read |
| empty | output | 1 | Nothing available to read (registered) |
| prog_empty | output | 1 | Readable count at or below AE_LEVEL |
| rd_err | output | 1 | Previous read was refused |
| rd_busy | output | 1 | Read side still coming out of reset |

## Verification
The assertions assume that both resets are asserted together and held for at least as many cycles as there are synchronizer stages, so that the two position counters restart from a common zero. They also assume that the enables change only between clock edges. The bench meets these conditions: it holds both resets for four cycles of each clock before releasing them, and it drives every input on the falling edge of the clock of that input's domain. Flags are compared against the stored-word count only after the bench has left both sides idle long enough for the synchronized positions to catch up.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    // Outcome of one access request on either side
    typedef enum logic [1:0] {
        ACC_IDLE   = 2'd0,
        ACC_TAKE   = 2'd1,
        ACC_REFUSE = 2'd2
    } acc_t;

    // A request is refused if the side is busy or the buffer blocks it
    function automatic acc_t classify(input logic req, input logic blocked);
        if (!req)
            return ACC_IDLE;
        else if (blocked)
            return ACC_REFUSE;
        else
            return ACC_TAKE;
    endfunction

endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[0] <= '0;
                    else     stg[0] <= d;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) stg[s] <= '0;
                    else     stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_rst_busy.sv
module dcf_rst_busy #(
    parameter int BUSY_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    output logic busy
);
    localparam int CW = $clog2(BUSY_CYC + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_CYC);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= LOAD;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R6: busy must be high in the first cycle after release
    a_r6_busy_after_release: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> busy);
    // R6: once low, busy stays low until the next reset
    a_r6_busy_no_return: assert property (@(posedge clk) disable iff (rst)
        !busy |=> !busy);
endmodule

// File: rtl/dcf_ram.sv
module dcf_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (re) rdata <= mem[raddr];
    end
endmodule

// File: rtl/dcf_wr_ctl.sv
module dcf_wr_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              wr_en,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              full,
    output logic              wr_err,
    output logic              we,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray
);
    localparam int PW    = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    acc_t            acc;
    logic [PW-1:0]   wbin, wbin_nx, wgray_nx, full_mark, rbin_s, occ_w;
    logic            full_nx;

    assign acc = classify(wr_en, full || busy);
    assign we  = (acc == ACC_TAKE);

    always_comb begin
        wbin_nx   = wbin + {{(PW-1){1'b0}}, we};
        wgray_nx  = wbin_nx ^ (wbin_nx >> 1);
        full_mark = {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]};
        full_nx   = (wgray_nx == full_mark);
    end

    // Binary view of the synchronized read position (checking only)
    always_comb begin
        rbin_s[PW-1] = rgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
        occ_w = wbin - rbin_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wbin   <= '0;
            wgray  <= '0;
            full   <= 1'b0;
            wr_err <= 1'b0;
        end else begin
            wbin   <= wbin_nx;
            wgray  <= wgray_nx;
            full   <= full_nx;
            wr_err <= (acc == ACC_REFUSE);
        end
    end

    assign waddr = wbin[ADDR_W-1:0];

    // R2: a write against a full buffer leaves the position unchanged
    a_r2_hold_when_full: assert property (@(posedge clk) disable iff (rst)
        (wr_en && full) |=> $stable(wbin));
    // R2: the writer never runs more than DEPTH words ahead
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
        occ_w <= PW'(DEPTH));
    // R3: without a request there is no error in the next cycle
    a_r3_err_clears: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> !wr_err);
    // R6: the position stays at zero while busy
    a_r6_wzero_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (wbin == '0));
endmodule

// File: rtl/dcf_rd_ctl.sv
module dcf_rd_ctl
    import dcf_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int AE_LEVEL = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              rd_en,
    input  logic [ADDR_W:0]   wgray_s,
    output logic              empty,
    output logic              prog_empty,
    output logic              rd_err,
    output logic              re,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] AE_MARK = PW'(AE_LEVEL);

    acc_t          acc;
    logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, occ_nx;
    logic          empty_nx, pe_nx;

    assign acc = classify(rd_en, empty || busy);
    assign re  = (acc == ACC_TAKE);

    always_comb begin
        rbin_nx  = rbin + {{(PW-1){1'b0}}, re};
        rgray_nx = rbin_nx ^ (rbin_nx >> 1);
        empty_nx = (rgray_nx == wgray_s);
    end

    // Occupancy from the (possibly stale) write position: never too high
    always_comb begin
        wbin_s[PW-1] = wgray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--)
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
        occ_nx = wbin_s - rbin_nx;
        pe_nx  = (occ_nx <= AE_MARK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rbin       <= '0;
            rgray      <= '0;
            empty      <= 1'b1;
            prog_empty <= 1'b1;
            rd_err     <= 1'b0;
        end else begin
            rbin       <= rbin_nx;
            rgray      <= rgray_nx;
            empty      <= empty_nx;
            prog_empty <= pe_nx;
            rd_err     <= (acc == ACC_REFUSE);
        end
    end

    assign raddr = rbin[ADDR_W-1:0];

    // R4: a read from an empty buffer leaves the position unchanged
    a_r4_hold_when_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty) |=> $stable(rbin));
    // R4: without a request there is no error in the next cycle
    a_r4_err_clears: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_err);
    // R5: a read request while busy is always refused
    a_r5_err_busy: assert property (@(posedge clk) disable iff (rst)
        (rd_en && busy) |=> rd_err);
    // R6: the position stays at zero while busy
    a_r6_rzero_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rbin == '0));
    // R7: an empty buffer is always reported almost empty
    a_r7_empty_is_low: assert property (@(posedge clk) disable iff (rst)
        empty |-> prog_empty);
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 4,
    parameter int AE_LEVEL    = 3,
    parameter int BUSY_CYC    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              wr_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full,
    output logic              wr_err,
    output logic              wr_busy,
    input  logic              rd_clk,
    input  logic              rd_rst,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty,
    output logic              prog_empty,
    output logic              rd_err,
    output logic              rd_busy
);
    localparam int PW = ADDR_W + 1;

    logic              we, re;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;

    dcf_rst_busy #(.BUSY_CYC(BUSY_CYC)) u_wbusy (
        .clk(wr_clk), .rst(wr_rst), .busy(wr_busy));

    dcf_rst_busy #(.BUSY_CYC(BUSY_CYC)) u_rbusy (
        .clk(rd_clk), .rst(rd_rst), .busy(rd_busy));

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wr_clk), .rst(wr_rst), .d(rgray), .q(rgray_s));

    dcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rd_clk), .rst(rd_rst), .d(wgray), .q(wgray_s));

    dcf_wr_ctl #(.ADDR_W(ADDR_W)) u_wctl (
        .clk(wr_clk), .rst(wr_rst), .busy(wr_busy), .wr_en(wr_en),
        .rgray_s(rgray_s), .full(full), .wr_err(wr_err),
        .we(we), .waddr(waddr), .wgray(wgray));

    dcf_rd_ctl #(.ADDR_W(ADDR_W), .AE_LEVEL(AE_LEVEL)) u_rctl (
        .clk(rd_clk), .rst(rd_rst), .busy(rd_busy), .rd_en(rd_en),
        .wgray_s(wgray_s), .empty(empty), .prog_empty(prog_empty),
        .rd_err(rd_err), .re(re), .raddr(raddr), .rgray(rgray));

    dcf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wr_clk), .we(we), .waddr(waddr), .wdata(wr_data),
        .rclk(rd_clk), .re(re), .raddr(raddr), .rdata(rd_data));

    // R3: a write against a full buffer raises the error next cycle
    a_r3_err_on_full: assert property (@(posedge wr_clk) disable iff (wr_rst)
        (wr_en && full) |=> wr_err);
    // R4: a read against an empty buffer raises the error next cycle
    a_r4_err_on_empty: assert property (@(posedge rd_clk) disable iff (rd_rst)
        (rd_en && empty) |=> rd_err);
endmodule

// File: tb/dcf_fifo_test.sv
module dcf_fifo_test;
    localparam int WR_PERIOD = 10;
    localparam int RD_PERIOD = 14;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;
    localparam int AE    = 3;
    localparam int BUSY  = 4;

    // step = {writes[5:0], reads[5:0], expected count[4:0]}
    localparam int NSTEP = 7;
    localparam logic [16:0] STEPS [NSTEP] = '{
        {6'd5,  6'd0,  5'd5},
        {6'd0,  6'd3,  5'd2},
        {6'd16, 6'd0,  5'd16},
        {6'd0,  6'd18, 5'd0},
        {6'd3,  6'd0,  5'd3},
        {6'd1,  6'd0,  5'd4},
        {6'd0,  6'd5,  5'd0}
    };

    logic wr_clk = 0, rd_clk = 0;
    logic wr_rst = 1, rd_rst = 1, wr_en = 0, rd_en = 0;
    logic [DW-1:0] wr_data = '0, rd_data;
    logic full, wr_err, wr_busy, empty, prog_empty, rd_err, rd_busy;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] model [$];
    logic [DW-1:0] seq = 8'h11;

    always #(WR_PERIOD/2) wr_clk = ~wr_clk;
    always #(RD_PERIOD/2) rd_clk = ~rd_clk;

    dcf_fifo #(.DATA_W(DW), .ADDR_W(AW), .AE_LEVEL(AE), .BUSY_CYC(BUSY)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_data(wr_data),
        .full(full), .wr_err(wr_err), .wr_busy(wr_busy),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en), .rd_data(rd_data),
        .empty(empty), .prog_empty(prog_empty), .rd_err(rd_err), .rd_busy(rd_busy));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic hold_reset();
        wr_rst = 1; rd_rst = 1; wr_en = 0; rd_en = 0;
        model.delete();
        repeat (4) @(negedge wr_clk);
        repeat (4) @(negedge rd_clk);
    endtask

    task automatic settle();
        repeat (6) @(negedge wr_clk);
        repeat (6) @(negedge rd_clk);
    endtask

    task automatic do_writes(input int n);
        bit drop = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge wr_clk);
            if (i > 0) chk(wr_err == drop, "R3 wr_err per attempt", wr_err, drop);
            drop = (model.size() == DEPTH);
            wr_en = 1; wr_data = seq;
            if (!drop) model.push_back(seq);
            seq = seq + 8'h07;
        end
        if (n > 0) begin
            @(negedge wr_clk);
            chk(wr_err == drop, "R3 wr_err last attempt", wr_err, drop);
            wr_en = 0;
            @(negedge wr_clk);
            chk(wr_err == 0, "R3 wr_err clears", wr_err, 0);
        end
    endtask

    task automatic do_reads(input int n);
        for (int i = 0; i < n; i++) begin
            bit under;
            logic [DW-1:0] exp_d;
            @(negedge rd_clk);
            under = (model.size() == 0);
            rd_en = 1;
            @(negedge rd_clk);
            rd_en = 0;
            chk(rd_err == under, "R4 rd_err per attempt", rd_err, under);
            if (!under) begin
                exp_d = model.pop_front();
                chk(rd_data == exp_d, "R1 read order", rd_data, exp_d);
            end
        end
        if (n > 0) begin
            @(negedge rd_clk);
            chk(rd_err == 0, "R4 rd_err clears", rd_err, 0);
        end
    endtask

    task automatic check_flags(input int c, input string tag);
        chk(full == (c == DEPTH), {tag, " R2 full"}, full, c == DEPTH);
        chk(empty == (c == 0), {tag, " R4 empty"}, empty, c == 0);
        chk(prog_empty == (c <= AE), {tag, " R7 prog_empty"}, prog_empty, c <= AE);
    endtask

    initial begin
        repeat (100000) @(posedge wr_clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog act=hung exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n;
        // R8 reset values
        hold_reset();
        chk(full == 0, "R8 full", full, 0);
        chk(empty == 1, "R8 empty", empty, 1);
        chk(prog_empty == 1, "R8 prog_empty", prog_empty, 1);
        chk(wr_err == 0 && rd_err == 0, "R8 err flags", {wr_err, rd_err}, 0);
        chk(wr_busy && rd_busy, "R8 busy", {wr_busy, rd_busy}, 3);

        // R6 busy duration on each side
        @(negedge wr_clk); wr_rst = 0;
        n = 0;
        while (wr_busy && n < 100) begin n++; @(negedge wr_clk); end
        chk(n == BUSY, "R6 wr_busy length", n, BUSY);
        @(negedge rd_clk); rd_rst = 0;
        n = 0;
        while (rd_busy && n < 100) begin n++; @(negedge rd_clk); end
        chk(n == BUSY, "R6 rd_busy length", n, BUSY);
        settle();

        // Table of stimulus and expected occupancy
        for (int s = 0; s < NSTEP; s++) begin
            do_writes(int'(STEPS[s][16:11]));
            do_reads(int'(STEPS[s][10:5]));
            settle();
            chk(model.size() == int'(STEPS[s][4:0]), "R2 model count", model.size(), STEPS[s][4:0]);
            check_flags(int'(STEPS[s][4:0]), $sformatf("step%0d", s));
        end

        // R9 full release latency
        do_writes(DEPTH);
        settle();
        chk(full == 1, "R9 full before read", full, 1);
        do_reads(1);
        chk(full == 1, "R9 full still set right after read", full, 1);
        n = 0;
        while (full && n < 50) begin n++; @(negedge wr_clk); end
        chk(n <= 8, "R9 full release cycles", n, 8);
        do_reads(DEPTH - 1);
        settle();
        check_flags(0, "drained");

        // R9 and R7 empty / prog_empty release latency
        do_writes(1);
        chk(empty == 1, "R9 empty still set right after write", empty, 1);
        chk(prog_empty == 1, "R7 no over-report", prog_empty, 1);
        n = 0;
        while (empty && n < 50) begin n++; @(negedge rd_clk); end
        chk(n <= 8, "R9 empty release cycles", n, 8);
        do_reads(1);
        settle();

        // R3 R5 R6 accesses during busy are refused and store nothing
        hold_reset();
        @(negedge wr_clk); wr_rst = 0; wr_en = 1; wr_data = 8'hA5;
        @(negedge wr_clk); wr_en = 0;
        chk(wr_err == 1, "R3 wr_err during busy", wr_err, 1);
        @(negedge rd_clk); rd_rst = 0; rd_en = 1;
        @(negedge rd_clk); rd_en = 0;
        chk(rd_err == 1, "R5 rd_err during busy", rd_err, 1);
        repeat (BUSY + 2) @(negedge wr_clk);
        repeat (BUSY + 2) @(negedge rd_clk);
        settle();
        check_flags(0, "R6 after busy");
        do_writes(1);
        settle();
        do_reads(1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule